// File: doc/BRIEF.md
# Nine-Level Bus Value Resolver

This block computes the single value seen on a shared bus when several drivers each present a value from a nine-level logic system. The levels are uninitialised, forcing conflict, strong zero, strong one, undriven, weak conflict, weak zero, weak one and don't-care. Each level is carried as a 4-bit two-state code, so the block can sit in ordinary synthesizable logic. Typical uses are emulating a tri-state bus inside a fabric that has no internal tri-states, or scoring the outcome of a multi-driver net in a hardware model.

Driver 0 is combined with driver 1 through a fixed pairwise strength rule. The result is then combined with driver 2, then driver 3, and so on up to the last driver. The number of drivers is a parameter. A second parameter places one register stage on the output for timing closure; without it the path from inputs to output is purely combinational.

Top module: `bus_resolver`

## Requirements
- R1: Level codes are U=0, X=1, strong 0=2, strong 1=3, Z=4, W=5, L=6, H=7, D=8. An input code from 9 to 15 behaves exactly like X. The output only ever carries codes 0 to 7.
- R2: When any driver presents U, the output is U, whatever the other drivers present.
- R3: When no driver presents U and at least one presents X, D or a code of 9 to 15, the output is X.
- R4: With no U, X or D present, a strong 0 together with a strong 1 gives X. A strong value that has no opposing strong value wins over any mix of Z, W, L and H.
- R5: Z is neutral: it leaves any other value unchanged, and when every driver presents Z the output is Z.
- R6: Among weak values with no strong value present: L with H gives W, W with any of W, L or H gives W, L alone (with Z) gives L, and H alone (with Z) gives H.
- R7: Drivers are folded from index 0 upward. Examples: drivers (U,0,0,1) give U, drivers (0,Z,0,L) give 0, drivers (Z,1,0) give X.
- R8: With one driver, the output equals that driver, except that D and codes 9 to 15 give X.
- R9: With REGISTER_OUT=1 the output follows the drivers one clock later and holds its value between edges; a synchronous reset (rst high at a rising edge) sets it to U. With REGISTER_OUT=0 the output follows the drivers within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset, output to U |
| drv_in | input | 4*N_DRV | Driver codes, driver i in bits [4*i+3:4*i] |
| bus_out | output | 4 | Resolved bus level code |

## Verification
Two resolution rules often apply at once: a strong conflict or a don't-care can sit in the same vector as a U, and a strong value can share the vector with a weak conflict. The bench builds such vectors on purpose, for example U together with opposing strong values, or D together with L and H. It then checks that the rule with the higher precedence decides the result: U beats X, and a strong value beats W. The registered variant is also checked the cycle before each update, to confirm the old value still holds while the new vector waits at the inputs.

// File: rtl/lvl9_pkg.sv
package lvl9_pkg;

  localparam int LVL_W = 4;

  localparam logic [LVL_W-1:0] LV_U = 4'd0;
  localparam logic [LVL_W-1:0] LV_X = 4'd1;
  localparam logic [LVL_W-1:0] LV_0 = 4'd2;
  localparam logic [LVL_W-1:0] LV_1 = 4'd3;
  localparam logic [LVL_W-1:0] LV_Z = 4'd4;
  localparam logic [LVL_W-1:0] LV_W = 4'd5;
  localparam logic [LVL_W-1:0] LV_L = 4'd6;
  localparam logic [LVL_W-1:0] LV_H = 4'd7;
  localparam logic [LVL_W-1:0] LV_D = 4'd8;

  // Any code outside the nine legal levels is folded onto the forcing conflict.
  function automatic logic [LVL_W-1:0] lvl9_clean(input logic [LVL_W-1:0] c);
    return (c > LV_D) ? LV_X : c;
  endfunction

  function automatic logic lvl9_is_strong(input logic [LVL_W-1:0] c);
    return (c == LV_0) || (c == LV_1);
  endfunction

  function automatic logic lvl9_is_poison(input logic [LVL_W-1:0] c);
    return (c == LV_X) || (c == LV_D) || (c > LV_D);
  endfunction

  // Pairwise resolution, written as a precedence ladder rather than a lookup.
  function automatic logic [LVL_W-1:0] lvl9_pair_fn(input logic [LVL_W-1:0] a,
                                                    input logic [LVL_W-1:0] b);
    logic [LVL_W-1:0] r;
    if ((a == LV_U) || (b == LV_U))
      r = LV_U;
    else if (lvl9_is_poison(a) || lvl9_is_poison(b))
      r = LV_X;
    else if (lvl9_is_strong(a) && lvl9_is_strong(b))
      r = (a == b) ? a : LV_X;
    else if (lvl9_is_strong(a))
      r = a;
    else if (lvl9_is_strong(b))
      r = b;
    else if (a == LV_Z)
      r = b;
    else if (b == LV_Z)
      r = a;
    else if (a == b)
      r = a;
    else
      r = LV_W;
    return r;
  endfunction

endpackage

// File: rtl/lvl9_clean.sv
module lvl9_clean #(
  parameter int N_LANE = 4
) (
  input  logic [4*N_LANE-1:0] raw_in,
  output logic [4*N_LANE-1:0] clean_out
);
  import lvl9_pkg::*;

  for (genvar i = 0; i < N_LANE; i++) begin : g_lane
    assign clean_out[LVL_W*i +: LVL_W] = lvl9_clean(raw_in[LVL_W*i +: LVL_W]);
  end

endmodule

// File: rtl/lvl9_pair.sv
module lvl9_pair (
  input  logic [3:0] lhs,
  input  logic [3:0] rhs,
  output logic [3:0] res
);
  import lvl9_pkg::*;

  always_comb res = lvl9_pair_fn(lhs, rhs);

endmodule

// File: rtl/lvl9_fold.sv
module lvl9_fold #(
  parameter int N_LANE = 4
) (
  input  logic [4*N_LANE-1:0] lanes,
  output logic [3:0]          folded
);
  import lvl9_pkg::*;

  // Seeding the chain with Z leaves driver 0 unchanged except D becomes X,
  // which also gives the single-driver behaviour without a special case.
  logic [LVL_W-1:0] acc [0:N_LANE];

  assign acc[0] = LV_Z;

  for (genvar i = 0; i < N_LANE; i++) begin : g_step
    lvl9_pair u_pair (
      .lhs (acc[i]),
      .rhs (lanes[LVL_W*i +: LVL_W]),
      .res (acc[i+1])
    );
  end

  assign folded = acc[N_LANE];

endmodule

// File: rtl/lvl9_out_stage.sv
module lvl9_out_stage #(
  parameter bit REGISTER_OUT = 1'b1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [3:0] d,
  output logic [3:0] q
);
  import lvl9_pkg::*;

  if (REGISTER_OUT) begin : g_reg
    logic [LVL_W-1:0] q_r;
    always_ff @(posedge clk) begin
      if (rst) q_r <= LV_U;
      else     q_r <= d;
    end
    assign q = q_r;
  end else begin : g_comb
    logic unused_clk_rst;
    assign unused_clk_rst = clk ^ rst;
    assign q = d;
  end

endmodule

// File: rtl/bus_resolver.sv
module bus_resolver #(
  parameter int N_DRV        = 4,
  parameter bit REGISTER_OUT = 1'b1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [4*N_DRV-1:0] drv_in,
  output logic [3:0]         bus_out
);
  import lvl9_pkg::*;

  localparam int BUS_W = LVL_W * N_DRV;

  logic [BUS_W-1:0] lanes_clean;
  logic [LVL_W-1:0] resolved;

  lvl9_clean #(.N_LANE(N_DRV)) u_clean (
    .raw_in    (drv_in),
    .clean_out (lanes_clean)
  );

  lvl9_fold #(.N_LANE(N_DRV)) u_fold (
    .lanes  (lanes_clean),
    .folded (resolved)
  );

  lvl9_out_stage #(.REGISTER_OUT(REGISTER_OUT)) u_out (
    .clk (clk),
    .rst (rst),
    .d   (resolved),
    .q   (bus_out)
  );

endmodule

// File: rtl/bus_resolver_chk.sv
module bus_resolver_chk #(
  parameter int N_DRV        = 4,
  parameter bit REGISTER_OUT = 1'b1
) (
  input logic               clk,
  input logic               rst,
  input logic [4*N_DRV-1:0] drv_in,
  input logic [3:0]         bus_out
);
  logic any_u, any_bad, all_z;

  always_comb begin
    any_u   = 1'b0;
    any_bad = 1'b0;
    all_z   = 1'b1;
    for (int i = 0; i < N_DRV; i++) begin
      if (drv_in[4*i +: 4] == 4'd0) any_u = 1'b1;
      if ((drv_in[4*i +: 4] == 4'd1) || (drv_in[4*i +: 4] >= 4'd8)) any_bad = 1'b1;
      if (drv_in[4*i +: 4] != 4'd4) all_z = 1'b0;
    end
  end

  if (REGISTER_OUT) begin : g_reg_props
    assert_u_dominates_R2: assert property (@(posedge clk) disable iff (rst)
      any_u |=> (bus_out == 4'd0));
    assert_poison_gives_x_R3: assert property (@(posedge clk) disable iff (rst)
      (!any_u && any_bad) |=> (bus_out == 4'd1));
    assert_all_z_R5: assert property (@(posedge clk) disable iff (rst)
      all_z |=> (bus_out == 4'd4));
    assert_reset_to_u_R9: assert property (@(posedge clk)
      rst |=> (bus_out == 4'd0));
  end else begin : g_comb_props
    assert_u_dominates_R2: assert property (@(posedge clk) disable iff (rst)
      any_u |-> (bus_out == 4'd0));
    assert_poison_gives_x_R3: assert property (@(posedge clk) disable iff (rst)
      (!any_u && any_bad) |-> (bus_out == 4'd1));
    assert_all_z_R5: assert property (@(posedge clk) disable iff (rst)
      all_z |-> (bus_out == 4'd4));
  end

  assert_legal_code_R1: assert property (@(posedge clk) disable iff (rst)
    bus_out <= 4'd7);

endmodule

bind bus_resolver bus_resolver_chk #(
  .N_DRV        (N_DRV),
  .REGISTER_OUT (REGISTER_OUT)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .drv_in  (drv_in),
  .bus_out (bus_out)
);

// File: tb/test_bus_resolver.sv
module test_bus_resolver;

  localparam logic [3:0] C_U = 4'd0, C_X = 4'd1, C_0 = 4'd2, C_1 = 4'd3,
                         C_Z = 4'd4, C_W = 4'd5, C_L = 4'd6, C_H = 4'd7, C_D = 4'd8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] d4  = '0;
  logic [11:0] d3  = '0;
  logic [3:0]  d1  = '0;
  logic [3:0]  out4, out3, out1;
  logic [3:0]  prev4;
  int          checks = 0;
  int          errors = 0;

  always #4 clk = ~clk;

  bus_resolver #(.N_DRV(4), .REGISTER_OUT(1'b1)) i_bus_resolver (
    .clk(clk), .rst(rst), .drv_in(d4), .bus_out(out4));

  bus_resolver #(.N_DRV(3), .REGISTER_OUT(1'b0)) i_bus_resolver_comb (
    .clk(clk), .rst(rst), .drv_in(d3), .bus_out(out3));

  bus_resolver #(.N_DRV(1), .REGISTER_OUT(1'b0)) i_bus_resolver_one (
    .clk(clk), .rst(rst), .drv_in(d1), .bus_out(out1));

  function automatic logic [15:0] p4(input logic [3:0] a, b, c, d);
    return {d, c, b, a};
  endfunction

  function automatic logic [11:0] p3(input logic [3:0] a, b, c);
    return {c, b, a};
  endfunction

  task automatic chk(input logic [3:0] got, input logic [3:0] exp,
                     input string req, input string what);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  // Drive both multi-driver instances; check the comb one at once, the
  // registered one holding before the edge and updated after it.
  task automatic apply(input logic [15:0] v4, input logic [3:0] e4,
                       input logic [11:0] v3, input logic [3:0] e3,
                       input string req);
    @(negedge clk);
    d4 = v4;
    d3 = v3;
    #1;
    chk(out3, e3, req, "three-driver comb");
    chk(out4, prev4, "R9", "registered hold before edge");
    @(posedge clk);
    #1;
    chk(out4, e4, req, "four-driver registered");
    prev4 = e4;
  endtask

  task automatic t_reset;
    @(posedge clk); #1;
    chk(out4, C_U, "R9", "reset value");
    @(negedge clk);
    rst = 1'b0;
    prev4 = C_U;
  endtask

  task automatic t_uninit;
    apply(p4(C_U, C_0, C_0, C_1), C_U, p3(C_1, C_Z, C_U), C_U, "R7 R2");
    apply(p4(C_0, C_1, C_D, C_U), C_U, p3(C_X, C_U, C_D), C_U, "R2");
  endtask

  task automatic t_poison;
    apply(p4(C_0, C_0, C_X, C_Z), C_X, p3(C_H, C_L, C_D), C_X, "R3");
    apply(p4(C_Z, C_D, C_Z, C_Z), C_X, p3(C_Z, C_Z, 4'd9), C_X, "R3");
    apply(p4(C_Z, C_Z, C_Z, 4'd12), C_X, p3(4'd15, C_1, C_1), C_X, "R1");
  endtask

  task automatic t_strong;
    apply(p4(C_0, C_Z, C_0, C_L), C_0, p3(C_Z, C_1, C_0), C_X, "R7 R4");
    apply(p4(C_Z, C_1, C_0, C_Z), C_X, p3(C_0, C_Z, C_0), C_0, "R4");
    apply(p4(C_1, C_H, C_W, C_L), C_1, p3(C_W, C_L, C_1), C_1, "R4");
    apply(p4(C_L, C_H, C_0, C_Z), C_0, p3(C_1, C_1, C_H), C_1, "R4");
  endtask

  task automatic t_undriven;
    apply(p4(C_Z, C_Z, C_Z, C_Z), C_Z, p3(C_Z, C_Z, C_H), C_H, "R5");
    apply(p4(C_Z, C_Z, C_L, C_Z), C_L, p3(C_Z, C_Z, C_Z), C_Z, "R5");
  endtask

  task automatic t_weak;
    apply(p4(C_L, C_H, C_Z, C_Z), C_W, p3(C_Z, C_W, C_Z), C_W, "R6");
    apply(p4(C_L, C_Z, C_L, C_Z), C_L, p3(C_H, C_Z, C_H), C_H, "R6");
    apply(p4(C_W, C_L, C_Z, C_Z), C_W, p3(C_H, C_W, C_Z), C_W, "R6");
    apply(p4(C_H, C_H, C_Z, C_H), C_H, p3(C_H, C_H, C_L), C_W, "R6");
  endtask

  task automatic t_single;
    for (int c = 0; c < 16; c++) begin
      logic [3:0] e;
      e = (c >= 8) ? C_X : 4'(c);
      d1 = 4'(c);
      #1;
      chk(out1, e, "R8", $sformatf("single driver code %0d", c));
    end
  endtask

  task automatic t_reset_midrun;
    @(negedge clk);
    d4 = p4(C_1, C_Z, C_Z, C_Z);
    @(posedge clk); #1;
    chk(out4, C_1, "R9", "value before reset");
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk); #1;
    chk(out4, C_U, "R9", "synchronous reset mid-run");
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk); #1;
    chk(out4, C_1, "R9", "resume after reset");
    prev4 = C_1;
  endtask

  initial begin
    #(8 * 20000);
    errors++;
    $display("FAIL R9 watchdog: got 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    prev4 = C_U;
    t_reset();
    t_uninit();
    t_poison();
    t_strong();
    t_undriven();
    t_weak();
    t_single();
    t_reset_midrun();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule